// File: doc/BRIEF.md
# Parallel Modulation Word Router

This block sits between a parallel modulation port and the control inputs of a direct digital synthesizer. Each captured 18-bit port word carries a 16-bit data field and a 2-bit destination code. When the capture strobe is high, the code picks which synthesizer control word the data drives: amplitude, phase, frequency, or a combined polar update of phase and amplitude.

For a frequency update, the data field is an unsigned offset. It is shifted left by a programmable 4-bit gain and added, modulo 2^32, to a base tuning word. Control words that the code does not select keep their last values. After reset each output register is seeded from its base input, so the synthesizer starts from the programmed base settings until modulation words arrive. If a capture strobe falls in the seeding cycle, the seeding takes precedence and the strobe is dropped.

Top module: `mod_word_router`

## Requirements
- R1: While rst_ni is low, ftw_o, phase_o and amp_o are zero. On the first rising clock edge after reset is released, they load base_ftw_i, base_phase_i and base_amp_i.
- R2: The data field is port_word_i[17:2] and the destination code is port_word_i[1:0]. The data is unsigned: data 0xFFFF with gain 0 adds +65535 to the base.
- R3: Code 00 (amplitude): amp_o takes data[15:2] one edge after the capture.
- R4: Code 01 (phase): phase_o takes all 16 data bits one edge after the capture.
- R5: Code 10 (frequency): ftw_o takes base_ftw_i + (data << fm_gain_i), using the base and gain present at the capture edge. Gain 0 aligns the data LSB with bit 0 of the tuning word.
- R6: A capture leaves every output that its code does not select unchanged.
- R7: With capture_i low, all outputs hold, even when port_word_i, base_ftw_i, base_phase_i, base_amp_i or fm_gain_i change.
- R8: Each gain step moves the data one bit further left. At gain 15 the data occupies tuning word bits 30:15.
- R9: The frequency sum is taken modulo 2^32: a carry out of bit 31 is discarded.
- R10: Code 11 (polar): phase_o takes {data[15:8], 8'h00} and amp_o takes {data[7:0], 6'b0}. ftw_o is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_word_i | input | 18 | Captured modulation word: data [17:2], destination code [1:0] |
| capture_i | input | 1 | Capture strobe; applies port_word_i at this edge |
| base_ftw_i | input | 32 | Base frequency tuning word |
| fm_gain_i | input | 4 | Left shift applied to the data before the frequency add |
| base_phase_i | input | 16 | Base phase, loaded after reset |
| base_amp_i | input | 14 | Base amplitude, loaded after reset |
| ftw_o | output | 32 | Registered frequency tuning word |
| phase_o | output | 16 | Registered phase word |
| amp_o | output | 14 | Registered amplitude word |

## Verification
Each routed result appears after exactly one register stage. A capture sampled at one rising edge is visible on the outputs just after that edge, and the base seeding is visible just after the first edge following reset release. The bench drives the port word and strobe on a falling edge, lowers the strobe on the next falling edge, and compares all three outputs at that second falling edge, half a cycle after the edge that updated them. Hold checks compare the outputs after idle cycles with changed inputs, again at falling edges.

// File: rtl/mwr_pkg.sv
`timescale 1ns/1ps
package mwr_pkg;
  typedef enum logic [1:0] {
    DEST_AMP   = 2'b00,
    DEST_PHASE = 2'b01,
    DEST_FREQ  = 2'b10,
    DEST_POLAR = 2'b11
  } dest_e;
endpackage

// File: rtl/mwr_field_split.sv
`timescale 1ns/1ps
module mwr_field_split
  import mwr_pkg::*;
#(
  parameter int PORT_W = 18,
  parameter int DATA_W = 16
) (
  input  logic [PORT_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output dest_e             dest_o
);
  localparam int DEST_W = PORT_W - DATA_W;

  assign data_o = word_i[PORT_W-1:DEST_W];
  assign dest_o = dest_e'(word_i[DEST_W-1:0]);
endmodule

// File: rtl/mwr_freq_offset.sv
`timescale 1ns/1ps
module mwr_freq_offset #(
  parameter int DATA_W = 16,
  parameter int FTW_W  = 32,
  parameter int GAIN_W = 4
) (
  input  logic [FTW_W-1:0]  base_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [FTW_W-1:0]  sum_o
);
  localparam int PAD_W = FTW_W - DATA_W;

  // log-depth shifter: stage s shifts by 2**s when gain bit s is set
  logic [FTW_W-1:0] stage [GAIN_W+1];
  assign stage[0] = {{PAD_W{1'b0}}, data_i};

  for (genvar s = 0; s < GAIN_W; s++) begin : g_shift
    always_comb begin
      if (gain_i[s]) stage[s+1] = stage[s] << (1 << s);
      else           stage[s+1] = stage[s];
    end
  end

  // modulo 2^FTW_W by width
  assign sum_o = base_i + stage[GAIN_W];
endmodule

// File: rtl/mwr_param_reg.sv
`timescale 1ns/1ps
module mwr_param_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/mod_word_router.sv
`timescale 1ns/1ps
module mod_word_router
  import mwr_pkg::*;
#(
  parameter int PORT_W  = 18,
  parameter int DATA_W  = 16,
  parameter int FTW_W   = 32,
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 14,
  parameter int GAIN_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PORT_W-1:0]  port_word_i,
  input  logic               capture_i,
  input  logic [FTW_W-1:0]   base_ftw_i,
  input  logic [GAIN_W-1:0]  fm_gain_i,
  input  logic [PHASE_W-1:0] base_phase_i,
  input  logic [AMP_W-1:0]   base_amp_i,
  output logic [FTW_W-1:0]   ftw_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [AMP_W-1:0]   amp_o
);
  localparam int BYTE_W   = 8;
  localparam int PH_PAD_W = PHASE_W - BYTE_W;
  localparam int AM_PAD_W = AMP_W - BYTE_W;

  logic [DATA_W-1:0] data;
  dest_e             dest;
  logic [FTW_W-1:0]  ftw_sum;
  logic              primed_q;

  logic               ftw_ld, ph_ld, am_ld;
  logic [FTW_W-1:0]   ftw_d;
  logic [PHASE_W-1:0] ph_d;
  logic [AMP_W-1:0]   am_d;

  mwr_field_split #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_split (
    .word_i (port_word_i),
    .data_o (data),
    .dest_o (dest)
  );

  mwr_freq_offset #(.DATA_W(DATA_W), .FTW_W(FTW_W), .GAIN_W(GAIN_W)) u_freq (
    .base_i (base_ftw_i),
    .data_i (data),
    .gain_i (fm_gain_i),
    .sum_o  (ftw_sum)
  );

  // first edge after reset seeds outputs from the base inputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  always_comb begin
    ftw_ld = 1'b0;
    ph_ld  = 1'b0;
    am_ld  = 1'b0;
    ftw_d  = ftw_sum;
    ph_d   = data[DATA_W-1 -: PHASE_W];
    am_d   = data[DATA_W-1 -: AMP_W];
    if (!primed_q) begin
      ftw_ld = 1'b1;
      ph_ld  = 1'b1;
      am_ld  = 1'b1;
      ftw_d  = base_ftw_i;
      ph_d   = base_phase_i;
      am_d   = base_amp_i;
    end else if (capture_i) begin
      unique case (dest)
        DEST_AMP:   am_ld  = 1'b1;
        DEST_PHASE: ph_ld  = 1'b1;
        DEST_FREQ:  ftw_ld = 1'b1;
        DEST_POLAR: begin
          ph_ld = 1'b1;
          am_ld = 1'b1;
          ph_d  = {data[DATA_W-1 -: BYTE_W], {PH_PAD_W{1'b0}}};
          am_d  = {data[BYTE_W-1:0], {AM_PAD_W{1'b0}}};
        end
        default: ;
      endcase
    end
  end

  mwr_param_reg #(.W(FTW_W)) u_ftw_reg (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (ftw_ld), .d_i (ftw_d), .q_o (ftw_o)
  );
  mwr_param_reg #(.W(PHASE_W)) u_phase_reg (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (ph_ld), .d_i (ph_d), .q_o (phase_o)
  );
  mwr_param_reg #(.W(AMP_W)) u_amp_reg (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (am_ld), .d_i (am_d), .q_o (amp_o)
  );
endmodule

// File: rtl/mwr_checker.sv
`timescale 1ns/1ps
module mwr_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [17:0] port_word_i,
  input logic        capture_i,
  input logic [31:0] base_ftw_i,
  input logic [3:0]  fm_gain_i,
  input logic [15:0] base_phase_i,
  input logic [13:0] base_amp_i,
  input logic [31:0] ftw_o,
  input logic [15:0] phase_o,
  input logic [13:0] amp_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  logic [63:0] offs_wide;
  assign offs_wide = {48'b0, port_word_i[17:2]} << fm_gain_i;

  AST_SEED_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |=> (ftw_o == $past(base_ftw_i)) && (phase_o == $past(base_phase_i))
                && (amp_o == $past(base_amp_i))) else $error("seed");  // R1

  AST_AMP_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && capture_i && port_word_i[1:0] == 2'b00
    |=> amp_o == $past(port_word_i[17:4]) && $stable(phase_o) && $stable(ftw_o))
    else $error("amp");  // R3

  AST_PHASE_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && capture_i && port_word_i[1:0] == 2'b01
    |=> phase_o == $past(port_word_i[17:2]) && $stable(amp_o) && $stable(ftw_o))
    else $error("phase");  // R4

  AST_FREQ_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && capture_i && port_word_i[1:0] == 2'b10
    |=> (ftw_o - $past(base_ftw_i)) == $past(offs_wide[31:0])
        && $stable(phase_o) && $stable(amp_o)) else $error("freq");  // R5

  AST_POLAR_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && capture_i && port_word_i[1:0] == 2'b11
    |=> phase_o == {$past(port_word_i[17:10]), 8'h00}
        && amp_o == {$past(port_word_i[9:2]), 6'b0} && $stable(ftw_o))
    else $error("polar");  // R10

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !capture_i |=> $stable(ftw_o) && $stable(phase_o) && $stable(amp_o))
    else $error("hold");  // R7
endmodule

bind mod_word_router mwr_checker u_chk (.*);

// File: tb/mod_word_router_tb_top.sv
`timescale 1ns/1ps
module mod_word_router_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] port_word_i = '0;
  logic        capture_i = 1'b0;
  logic [31:0] base_ftw_i = 32'h1000_0000;
  logic [3:0]  fm_gain_i = 4'd0;
  logic [15:0] base_phase_i = 16'h1234;
  logic [13:0] base_amp_i = 14'h0ABC;
  logic [31:0] ftw_o;
  logic [15:0] phase_o;
  logic [13:0] amp_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] e_ftw;
  logic [15:0] e_ph;
  logic [13:0] e_am;

  always #2.5 clk_i = ~clk_i;

  mod_word_router dut_i (.*);

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "ftw", ftw_o, e_ftw);
    chk(req, "phase", {16'b0, phase_o}, {16'b0, e_ph});
    chk(req, "amp", {18'b0, amp_o}, {18'b0, e_am});
  endtask

  task automatic capture(logic [15:0] data, logic [1:0] code);
    @(negedge clk_i);
    port_word_i = {data, code};
    capture_i   = 1'b1;
    @(negedge clk_i);
    capture_i   = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "ftw in reset", ftw_o, 32'h0);
    chk("R1", "phase in reset", {16'b0, phase_o}, 32'h0);
    chk("R1", "amp in reset", {18'b0, amp_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    e_ftw = 32'h1000_0000; e_ph = 16'h1234; e_am = 14'h0ABC;
    chk_all("R1");
  endtask

  task automatic t_hold();
    @(negedge clk_i);
    port_word_i  = {16'hDEAD, 2'b10};
    base_ftw_i   = 32'h2000_0000;
    base_phase_i = 16'h5555;
    base_amp_i   = 14'h1111;
    fm_gain_i    = 4'd3;
    repeat (3) @(negedge clk_i);
    chk_all("R7");
    fm_gain_i = 4'd0;
  endtask

  task automatic t_amp();
    capture(16'hBEEF, 2'b00);
    e_am = 14'h2FBB;                 // BEEF[15:2]
    chk_all("R3");
    chk("R6", "ftw kept", ftw_o, e_ftw);
  endtask

  task automatic t_phase();
    capture(16'hC0DE, 2'b01);
    e_ph = 16'hC0DE;
    chk_all("R4");
    chk("R6", "amp kept", {18'b0, amp_o}, {18'b0, e_am});
  endtask

  task automatic t_freq();
    base_ftw_i = 32'h1000_0000;
    fm_gain_i  = 4'd0;
    capture(16'hFFFF, 2'b10);
    e_ftw = 32'h1000_FFFF;           // unsigned +65535
    chk("R2", "unsigned offset", ftw_o, e_ftw);
    chk("R6", "phase kept", {16'b0, phase_o}, {16'b0, e_ph});
    fm_gain_i = 4'd5;
    capture(16'h0003, 2'b10);
    e_ftw = 32'h1000_0060;
    chk_all("R5");
  endtask

  task automatic t_gain15();
    base_ftw_i = 32'h0;
    fm_gain_i  = 4'd15;
    capture(16'h8001, 2'b10);
    e_ftw = 32'h4000_8000;
    chk_all("R8");
  endtask

  task automatic t_wrap();
    base_ftw_i = 32'hFFFF_0000;
    fm_gain_i  = 4'd4;
    capture(16'hFFFF, 2'b10);
    e_ftw = 32'h000E_FFF0;
    chk_all("R9");
  endtask

  task automatic t_polar();
    capture(16'hA55A, 2'b11);
    e_ph = 16'hA500;
    e_am = 14'h1680;
    chk_all("R10");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_hold();
    t_amp();
    t_phase();
    t_freq();
    t_gain15();
    t_wrap();
    t_polar();
    t_hold();
    repeat (2) @(negedge clk_i);
    finish_run();
  end

  initial begin
    #50000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule